// File: doc/BRIEF.md
# Shared LED Lock Arbiter

This block owns the lock on a shared LED output register and hands it to one of several remote processors at a time. Each processor talks to it through a pair of mailboxes: an inbound one that carries request words to the arbiter and an outbound one that carries reply words back. The mailboxes themselves are outside the block. The block sees them as valid/ready ports, one slot per processor.

Every word is four ASCII bytes. The low byte is a type letter and the next byte is the sender's processor digit. The third byte is a data digit and the top byte is a zero terminator. A processor presses a button by sending a 'B' word. When the lock is free, the arbiter records the sender's digit as the owner and answers with an acknowledge, which gives that processor the right to write the LED register. The holder then sends 'L' (LED ready). The arbiter acknowledges it, samples the LED register and releases the lock. Any request the arbiter cannot honour gets a negative acknowledge. A word whose processor digit is unreadable is dropped without a reply.

The arbiter serves one message at a time. When several inbound mailboxes present a word in the same cycle, a rotating pointer decides which one is taken first.

Top module: `lock_arbiter`

## Requirements
- R1: Word layout. Bits [7:0] hold the type letter, bits [15:8] the ASCII processor digit, bits [23:16] the ASCII data digit, and bits [31:24] are 0x00. Each reply has type 'A' (0x41) or 'N' (0x4E), echoes the sender's digit in bits [15:8], has '0' (0x30) in bits [23:16] and 0x00 in bits [31:24].
- R2: Each accepted word with a valid processor digit produces exactly one reply, on the outbound slot with the same index. That reply stays valid and unchanged until it is taken. No inbound word is accepted while a reply is pending, and at most one in_ready bit is high.
- R3: A well-formed 'B' (0x42) from digit n while the lock is free makes n the owner (lock_busy=1, lock_owner=n) and is answered with 'A'.
- R4: A 'B' from a digit other than the owner is answered with 'N' and leaves the lock unchanged. A 'B' from the owner is answered with 'A' and also leaves the lock unchanged.
- R5: A well-formed 'L' (0x4C) from the owner is answered with 'A'. In the cycle after that reply is taken, led_sample holds the value that led_in had at the hand-off, led_sample_valid is high for exactly one cycle, and lock_busy is 0.
- R6: An 'L' from a digit that does not own the lock, or an 'L' sent while the lock is free, is answered with 'N'.
- R7: A word with a valid processor digit but a malformed body is answered with 'N' and does not change the lock. Malformed means: a type letter outside G, A, N, L, B, R; a data byte that is not '0'..'9'; or a nonzero top byte. Well-formed 'G', 'A', 'N' and 'R' words are also answered with 'N'.
- R8: A word whose bits [15:8] are not '0'..'9' (0x30..0x39) is consumed and produces no reply.
- R9: When more than one inbound slot is valid, the first valid slot at or after a rotating pointer wins, and the pointer then moves to the slot after the winner. A lone request leaves the pointer where it is. After reset the pointer is at slot 0, so the first tie goes to slot 0 and the next tie to slot 1.
- R10: After reset no reply is valid, the lock is free, lock_owner is 0, led_sample is 0 and led_sample_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPROC | Inbound mailbox word present, one bit per processor |
| in_data | input | 32*NPROC | Inbound words, slot i at bits [32*i+31:32*i] |
| in_ready | output | NPROC | Inbound word taken this cycle |
| out_valid | output | NPROC | Reply word present on outbound slot |
| out_data | output | 32*NPROC | Reply words, slot layout as for in_data |
| out_ready | input | NPROC | Outbound mailbox accepts the reply |
| led_in | input | LED_W | Current LED register value (bit set means LED on) |
| led_sample | output | LED_W | LED value captured at lock release |
| led_sample_valid | output | 1 | One-cycle strobe for led_sample |
| lock_busy | output | 1 | Lock is owned |
| lock_owner | output | 4 | Digit value of the current owner |

## Verification
The bench walks a full grant and release cycle, then attacks the lock from the wrong processor with both 'B' and 'L'. This separates a correct ownership check from one that acknowledges any sender or compares the wrong byte. Separate malformed words break one field each (type letter, data digit, top byte) and show that each field is checked on its own. A word with an unreadable processor digit must vanish without a reply, while a valid-digit word with a broken body still gets an 'N'. A stalled outbound slot shows that the reply is held steady. Two back-to-back ties must be served in opposite orders, which tells a rotating pointer from a fixed priority.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;

  localparam int MSG_W = 32;

  localparam logic [7:0] CH_GRANT  = 8'h47;
  localparam logic [7:0] CH_ACK    = 8'h41;
  localparam logic [7:0] CH_NACK   = 8'h4E;
  localparam logic [7:0] CH_LEDRDY = 8'h4C;
  localparam logic [7:0] CH_BUTTON = 8'h42;
  localparam logic [7:0] CH_REQ    = 8'h52;
  localparam logic [7:0] CH_ZERO   = 8'h30;

  typedef enum logic [1:0] {MK_BUTTON, MK_LEDRDY, MK_OTHER, MK_BAD} msg_kind_e;
  typedef enum logic {S_IDLE, S_REPLY} arb_state_e;

  typedef struct packed {
    msg_kind_e  kind;
    logic       digit_ok;
    logic [3:0] digit;
  } msg_info_t;

  typedef struct packed {
    logic ack;
    logic take;
    logic free;
  } verdict_t;

  function automatic logic is_digit(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic logic [3:0] digit_val(input logic [7:0] c);
    return 4'(c - CH_ZERO);
  endfunction

  function automatic msg_info_t classify(input logic [MSG_W-1:0] w);
    msg_info_t m;
    logic [7:0] t, p, d, z;
    t = w[7:0];
    p = w[15:8];
    d = w[23:16];
    z = w[31:24];
    m.digit_ok = is_digit(p);
    m.digit    = digit_val(p);
    if (!is_digit(p) || !is_digit(d) || (z != 8'h00)) begin
      m.kind = MK_BAD;
    end else begin
      case (t)
        CH_BUTTON: m.kind = MK_BUTTON;
        CH_LEDRDY: m.kind = MK_LEDRDY;
        CH_GRANT, CH_ACK, CH_NACK, CH_REQ: m.kind = MK_OTHER;
        default:   m.kind = MK_BAD;
      endcase
    end
    return m;
  endfunction

  function automatic verdict_t judge(input msg_info_t m, input logic busy,
                                     input logic [3:0] owner);
    verdict_t v;
    v = '0;
    case (m.kind)
      MK_BUTTON: begin
        if (!busy) begin
          v.ack  = 1'b1;
          v.take = 1'b1;
        end else if (owner == m.digit) begin
          v.ack = 1'b1;
        end
      end
      MK_LEDRDY: begin
        if (busy && (owner == m.digit)) begin
          v.ack  = 1'b1;
          v.free = 1'b1;
        end
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [MSG_W-1:0] make_reply(input logic ack,
                                                   input logic [3:0] digit);
    return {8'h00, CH_ZERO, CH_ZERO + {4'h0, digit}, (ack ? CH_ACK : CH_NACK)};
  endfunction

endpackage

// File: rtl/lock_msg_decode.sv
module lock_msg_decode
  import lock_arb_pkg::*;
(
  input  logic [MSG_W-1:0] word_i,
  input  logic             busy_i,
  input  logic [3:0]       owner_i,
  output msg_info_t        info_o,
  output verdict_t         verdict_o
);
  always_comb begin
    info_o    = classify(word_i);
    verdict_o = judge(info_o, busy_i, owner_i);
  end
endmodule

// File: rtl/lock_rr_pick.sv
module lock_rr_pick #(
  parameter int NPROC = 2,
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [NPROC-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             tie_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int k = 0; k < NPROC; k++) begin
      int p;
      p = (int'(ptr_i) + k) % NPROC;
      if (!found && req_i[p]) begin
        found    = 1'b1;
        gnt_o[p] = 1'b1;
        idx_o    = IDX_W'(p);
      end
    end
    tie_o = ($countones(req_i) > 1);
  end
endmodule

// File: rtl/lock_owner_reg.sv
module lock_owner_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       free_i,
  input  logic [3:0] digit_i,
  output logic       busy_o,
  output logic [3:0] owner_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      owner_o <= 4'h0;
    end else if (take_i) begin
      busy_o  <= 1'b1;
      owner_o <= digit_i;
    end else if (free_i) begin
      busy_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lock_arb_pkg::*;
#(
  parameter int NPROC = 2,
  parameter int LED_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPROC-1:0]       in_valid,
  input  logic [NPROC*32-1:0]    in_data,
  output logic [NPROC-1:0]       in_ready,
  output logic [NPROC-1:0]       out_valid,
  output logic [NPROC*32-1:0]    out_data,
  input  logic [NPROC-1:0]       out_ready,
  input  logic [LED_W-1:0]       led_in,
  output logic [LED_W-1:0]       led_sample,
  output logic                   led_sample_valid,
  output logic                   lock_busy,
  output logic [3:0]             lock_owner
);
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1;

  arb_state_e       st;
  logic [IDX_W-1:0] rr_ptr, gnt_idx, src_idx;
  logic [NPROC-1:0] gnt;
  logic             tie;
  logic [MSG_W-1:0] in_words [NPROC];
  logic [MSG_W-1:0] cap_word, reply_word;
  msg_info_t        info;
  verdict_t         verdict;
  logic             free_pending;

  // named internal events, used by the checker
  logic in_fire, out_fire, take_evt, release_evt;

  for (genvar i = 0; i < NPROC; i++) begin : g_slot
    assign in_words[i] = in_data[i*MSG_W +: MSG_W];
    assign out_valid[i] = (st == S_REPLY) && (src_idx == IDX_W'(i));
    assign out_data[i*MSG_W +: MSG_W] = out_valid[i] ? reply_word : '0;
  end

  lock_rr_pick #(.NPROC(NPROC)) u_pick (
    .req_i (in_valid),
    .ptr_i (rr_ptr),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .tie_o (tie)
  );

  assign in_ready = (st == S_IDLE) ? gnt : '0;
  assign in_fire  = (st == S_IDLE) && (|in_valid);
  assign cap_word = in_words[gnt_idx];

  lock_msg_decode u_dec (
    .word_i    (cap_word),
    .busy_i    (lock_busy),
    .owner_i   (lock_owner),
    .info_o    (info),
    .verdict_o (verdict)
  );

  assign take_evt    = in_fire && info.digit_ok && verdict.take;
  assign out_fire    = (st == S_REPLY) && out_ready[src_idx];
  assign release_evt = out_fire && free_pending;

  lock_owner_reg u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take_evt),
    .free_i  (release_evt),
    .digit_i (info.digit),
    .busy_o  (lock_busy),
    .owner_o (lock_owner)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      src_idx      <= '0;
      reply_word   <= '0;
      free_pending <= 1'b0;
      rr_ptr       <= '0;
    end else begin
      if (in_fire && tie) begin
        rr_ptr <= (int'(gnt_idx) == NPROC - 1) ? '0 : gnt_idx + IDX_W'(1);
      end
      case (st)
        S_IDLE: begin
          if (in_fire && info.digit_ok) begin
            st           <= S_REPLY;
            src_idx      <= gnt_idx;
            reply_word   <= make_reply(verdict.ack, info.digit);
            free_pending <= verdict.free;
          end
        end
        default: begin
          if (out_fire) begin
            st           <= S_IDLE;
            free_pending <= 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_sample       <= '0;
      led_sample_valid <= 1'b0;
    end else begin
      led_sample_valid <= release_evt;
      if (release_evt) led_sample <= led_in;
    end
  end

endmodule

// File: rtl/lock_arbiter_chk.sv
module lock_arbiter_chk #(
  parameter int NPROC = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPROC-1:0]    in_ready,
  input logic [NPROC-1:0]    out_valid,
  input logic [NPROC-1:0]    out_ready,
  input logic [NPROC*32-1:0] out_data,
  input logic                led_sample_valid,
  input logic                lock_busy,
  input logic [3:0]          lock_owner,
  input logic                take_evt,
  input logic                release_evt
);
  a_r2_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  a_r2_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  a_r2_no_accept_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> (in_ready == '0));

  a_r2_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid != '0) && ((out_valid & out_ready) == '0))
      |=> ($stable(out_valid) && $stable(out_data)));

  for (genvar i = 0; i < NPROC; i++) begin : g_form
    a_r1_reply_form: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] |-> ((out_data[i*32+24 +: 8] == 8'h00) &&
                        (out_data[i*32+16 +: 8] == 8'h30) &&
                        ((out_data[i*32 +: 8] == 8'h41) ||
                         (out_data[i*32 +: 8] == 8'h4E))));
  end

  a_r3_take_replies: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> (lock_busy && (out_valid != '0)));

  a_r4_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_busy && $past(lock_busy)) |-> $stable(lock_owner));

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    led_sample_valid |=> !led_sample_valid);

  a_r5_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (led_sample_valid && !lock_busy));
endmodule

bind lock_arbiter lock_arbiter_chk #(.NPROC(NPROC)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_ready         (in_ready),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .led_sample_valid (led_sample_valid),
  .lock_busy        (lock_busy),
  .lock_owner       (lock_owner),
  .take_evt         (take_evt),
  .release_evt      (release_evt)
);

// File: tb/tb_lock_arbiter.sv
module tb_lock_arbiter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_valid = '0;
  logic [31:0] in_words [2] = '{32'h0, 32'h0};
  logic [63:0] in_data;
  logic [1:0]  in_ready, out_valid;
  logic [63:0] out_data;
  logic [1:0]  out_ready = 2'b11;
  logic [3:0]  led_in = 4'h0;
  logic [3:0]  led_sample;
  logic        led_sample_valid, lock_busy;
  logic [3:0]  lock_owner;

  assign in_data = {in_words[1], in_words[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_arbiter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .led_in(led_in), .led_sample(led_sample),
    .led_sample_valid(led_sample_valid), .lock_busy(lock_busy),
    .lock_owner(lock_owner)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_q0[$], exp_q1[$];
  logic [3:0]  exp_led[$];
  int          order_log[$];
  int          replies0 = 0;

  // reference lock model
  logic       m_busy = 0;
  logic [3:0] m_owner = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input byte t, input byte p, input byte d,
                                     input byte z);
    return {z, d, p, t};
  endfunction

  function automatic bit dg(input logic [7:0] c);
    return c >= 8'h30 && c <= 8'h39;
  endfunction

  // expectation for one word, applied in service order
  task automatic predict(input int mb, input logic [31:0] w);
    logic [7:0] t, p, d, z;
    logic [3:0] n;
    bit ack, good;
    t = w[7:0]; p = w[15:8]; d = w[23:16]; z = w[31:24];
    if (!dg(p)) return;                       // R8: silently dropped
    n = 4'(p - 8'h30);
    good = dg(d) && z == 8'h00 && (t inside {"G","A","N","L","B","R"});
    ack = 0;
    if (good && t == "B") begin
      if (!m_busy) begin m_busy = 1; m_owner = n; ack = 1; end
      else if (m_owner == n) ack = 1;
    end else if (good && t == "L" && m_busy && m_owner == n) begin
      ack = 1; m_busy = 0; exp_led.push_back(led_in);
    end
    if (mb == 0) exp_q0.push_back({8'h00, 8'h30, p, ack ? 8'h41 : 8'h4E});
    else         exp_q1.push_back({8'h00, 8'h30, p, ack ? 8'h41 : 8'h4E});
  endtask

  task automatic drive(input int mb, input logic [31:0] w);
    bit taken;
    @(negedge clk);
    in_words[mb] = w;
    in_valid[mb] = 1'b1;
    taken = 0;
    while (!taken) begin
      #1 taken = in_ready[mb];
      @(negedge clk);
    end
    in_valid[mb] = 1'b0;
  endtask

  task automatic send(input int mb, input logic [31:0] w);
    predict(mb, w);
    drive(mb, w);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare replies and LED samples against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (out_valid[i] && out_ready[i]) begin
          logic [31:0] got;
          got = out_data[i*32 +: 32];
          order_log.push_back(i);
          if (i == 0) replies0++;
          if ((i == 0 ? exp_q0.size() : exp_q1.size()) == 0)
            chk(0, "R2 unexpected reply", got, 32'h0);
          else begin
            logic [31:0] e;
            e = (i == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
            chk(got == e, "R1/R3/R4/R6/R7 reply word", got, e);
          end
        end
      end
      if (led_sample_valid) begin
        if (exp_led.size() == 0) chk(0, "R5 unexpected sample", {28'h0, led_sample}, 0);
        else begin
          logic [3:0] e;
          e = exp_led.pop_front();
          chk(led_sample == e, "R5 led sample", {28'h0, led_sample}, {28'h0, e});
          chk(!lock_busy, "R5 lock released", {31'h0, lock_busy}, 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && !lock_busy && lock_owner == 0 && led_sample == 0 &&
        !led_sample_valid, "R10 reset state",
        {22'h0, out_valid, lock_busy, led_sample_valid, lock_owner, led_sample}, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 grant to digit 0
    send(0, mk("B", "0", "0", 0)); idle(3);
    chk(lock_busy && lock_owner == 0, "R3 lock taken", {27'h0, lock_busy, lock_owner}, 32'h10);
    // R4 competing button
    send(1, mk("B", "1", "0", 0)); idle(3);
    chk(lock_busy && lock_owner == 0, "R4 lock unchanged", {27'h0, lock_busy, lock_owner}, 32'h10);
    // R6 LED ready from non-holder
    send(1, mk("L", "1", "0", 0)); idle(3);
    chk(lock_busy, "R6 lock kept", {31'h0, lock_busy}, 1);
    // R4 holder repeats button
    send(0, mk("B", "0", "0", 0)); idle(3);
    // R5 release with sample
    led_in = 4'b1010;
    send(0, mk("L", "0", "0", 0)); idle(4);
    chk(!lock_busy, "R5 free after release", {31'h0, lock_busy}, 0);
    // R6 LED ready while free
    send(0, mk("L", "0", "0", 0)); idle(3);
    // R7 malformed words with valid digits
    send(1, mk("X", "1", "0", 0));
    send(1, mk("B", "1", "0", 8'h5A));
    send(1, mk("B", "1", "z", 0));
    send(0, mk("G", "0", "0", 0));
    send(0, mk("R", "0", "0", 0));
    idle(3);
    chk(!lock_busy, "R7 lock unchanged", {31'h0, lock_busy}, 0);
    // R8 unreadable digit: no reply
    r0 = replies0;
    send(0, mk("B", "k", "0", 0)); idle(6);
    chk(replies0 == r0 && !lock_busy, "R8 word dropped", replies0, r0);
    // R3 grant to digit 1, then release
    send(1, mk("B", "1", "0", 0)); idle(3);
    chk(lock_busy && lock_owner == 1, "R3 lock to 1", {27'h0, lock_busy, lock_owner}, 32'h11);
    led_in = 4'b0101;
    send(1, mk("L", "1", "0", 0)); idle(4);

    // R2 backpressure: reply held while stalled
    out_ready[0] = 1'b0;
    send(0, mk("B", "3", "0", 0));
    begin
      logic [31:0] first;
      first = out_data[31:0];
      for (int k = 0; k < 4; k++) begin
        chk(out_valid[0] && out_data[31:0] == first && in_ready == 0,
            "R2 reply held", out_data[31:0], first);
        @(negedge clk);
      end
    end
    out_ready[0] = 1'b1;
    idle(2);
    led_in = 4'b1111;
    send(0, mk("L", "3", "0", 0)); idle(4);

    // R9 ties
    order_log.delete();
    predict(0, mk("X", "0", "0", 0));
    predict(1, mk("X", "1", "0", 0));
    fork
      drive(0, mk("X", "0", "0", 0));
      drive(1, mk("X", "1", "0", 0));
    join
    idle(4);
    predict(1, mk("X", "1", "0", 0));
    predict(0, mk("X", "0", "0", 0));
    fork
      drive(0, mk("X", "0", "0", 0));
      drive(1, mk("X", "1", "0", 0));
    join
    idle(4);
    chk(order_log.size() == 4, "R9 reply count", order_log.size(), 4);
    if (order_log.size() == 4)
      chk(order_log[0] == 0 && order_log[1] == 1 && order_log[2] == 1 &&
          order_log[3] == 0, "R9 rotation order",
          {order_log[0][7:0], order_log[1][7:0], order_log[2][7:0], order_log[3][7:0]},
          32'h00010100);

    // R2 every expected reply arrived
    chk(exp_q0.size() == 0 && exp_q1.size() == 0 && exp_led.size() == 0,
        "R2 scoreboard drained", exp_q0.size() + exp_q1.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule